// File: doc/BRIEF.md
# NAND Flash Read Strobe Sequencer

This block produces the read-enable strobe pattern for a burst of byte reads from an 8-bit NAND flash device. A controller issues a one-cycle start request together with a byte count and a bank's timing options. The options are a relaxed-timing bit, a strobe-shift bit, a 4-bit cycle scaler (SCY, 0 to 15) and an extended-hold enable. The sequencer then drives the chip select, the active-low read enable and a one-tick data-capture strobe for each byte. When the burst is over it raises a done pulse. A busy flag covers the whole burst.

The block runs from a clock at four times the bus clock. Every duration is counted in ticks of this clock, where one tick is a quarter of a bus cycle. This makes the three-quarter and one-half bus-cycle terms of the strobe low width exact. All options are sampled when a start is accepted and stay fixed until the burst ends.

The optional extended hold follows the last read. During it the chip select is released while the block stays busy, so that slow output drivers and bus transceivers have time to turn off before the next access.

Top module: `nand_read_strobe_seq`

## Requirements
- R1: Each read-enable low pulse lasts, in ticks, 3+4·SCY for (relaxed,shift)=(0,0), 4+4·SCY for (0,1), 2+8·SCY for (1,0) and 4+8·SCY for (1,1).
- R2: The start is accepted on a clock edge. From the tick after that edge, chip select (active low) is asserted and read enable stays high for 8+4·SCY ticks (relaxed=0) or 12+8·SCY ticks (relaxed=1). The first low pulse follows directly.
- R3: Between consecutive low pulses of one burst, read enable is high for 4 ticks (relaxed=0) or 8 ticks (relaxed=1), and chip select stays asserted.
- R4: The capture strobe is high for exactly one tick, the last tick of each read-enable low pulse. It therefore pulses once per byte.
- R5: After the last rise of read enable, chip select stays asserted with read enable high for 4·SCY ticks (relaxed=0) or 8·SCY ticks (relaxed=1). With SCY=0 this interval is absent.
- R6: With extended hold enabled, the hold interval is followed by 4 ticks (relaxed=0) or 8 ticks (relaxed=1) in which chip select is negated and busy stays high.
- R7: Busy is high from the tick after acceptance through the last interval of the burst. Done is then high for exactly one tick, with busy low. After that, done and busy are both low.
- R8: A start with a byte count of 0 gives done on the tick after acceptance, with busy low. It produces no read-enable pulse and leaves chip select negated.
- R9: A start request while busy is high is ignored. It does not change the burst in progress.
- R10: After reset, chip select and read enable are high (negated), and capture, done and busy are low.
- R11: Option and byte-count inputs that change after the start is accepted have no effect on the burst in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, four times the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst request, one tick |
| byte_cnt_i | input | CNT_W | Number of bytes to read |
| relaxed_i | input | 1 | Relaxed-timing option |
| shift_i | input | 1 | Strobe-shift option |
| scy_i | input | SCY_W | Cycle scaler |
| ext_hold_i | input | 1 | Extended-hold enable |
| cs_n_o | output | 1 | Chip select, active low |
| re_n_o | output | 1 | Read enable, active low |
| cap_o | output | 1 | Data-capture strobe |
| done_o | output | 1 | Burst complete, one tick |
| busy_o | output | 1 | Burst in progress |

## Verification
The bench predicts the full tick-by-tick waveform of every burst and compares each tick. A low width that is off by a quarter cycle, or that uses the wrong option pair, shows up as a read-enable edge one tick early or late. SCY=0 with relaxed timing exercises the two-tick low pulse and the missing hold interval. A design that always inserts a hold tick, or that leaves chip select asserted during the extended hold, fails there. Directed tests send a start while busy, change the options in the middle of a burst and request a zero-length burst. A design that restarts, re-reads its options or emits a stray strobe in these cases changes the waveform that is observed.

// File: rtl/nfr_pkg.sv
package nfr_pkg;
  localparam int QTR_PER_BUS = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_WAIT,
    PH_LOW,
    PH_HIGH,
    PH_HOLD,
    PH_EXT,
    PH_DONE
  } phase_e;
endpackage

// File: rtl/nfr_timing_calc.sv
module nfr_timing_calc #(
  parameter int SCY_W  = 4,
  parameter int TICK_W = SCY_W + 4
) (
  input  logic              relaxed_i,
  input  logic              shift_i,
  input  logic [SCY_W-1:0]  scy_i,
  output logic [TICK_W-1:0] wait_t_o,
  output logic [TICK_W-1:0] low_t_o,
  output logic [TICK_W-1:0] high_t_o,
  output logic [TICK_W-1:0] hold_t_o,
  output logic [TICK_W-1:0] ext_t_o
);
  import nfr_pkg::*;

  localparam logic [TICK_W-1:0] ONE_BUS = TICK_W'(QTR_PER_BUS);
  localparam logic [TICK_W-1:0] TWO_BUS = TICK_W'(2 * QTR_PER_BUS);

  logic [TICK_W-1:0] scy_x4;
  logic [TICK_W-1:0] scy_x8;

  always_comb begin
    scy_x4 = TICK_W'(scy_i) << 2;
    scy_x8 = TICK_W'(scy_i) << 3;

    if (relaxed_i) begin
      wait_t_o = TICK_W'(3 * QTR_PER_BUS) + scy_x8;
      high_t_o = TWO_BUS;
      hold_t_o = scy_x8;
      ext_t_o  = TWO_BUS;
      low_t_o  = shift_i ? (ONE_BUS + scy_x8) : (TICK_W'(2) + scy_x8);
    end else begin
      wait_t_o = TWO_BUS + scy_x4;
      high_t_o = ONE_BUS;
      hold_t_o = scy_x4;
      ext_t_o  = ONE_BUS;
      low_t_o  = shift_i ? (ONE_BUS + scy_x4) : (TICK_W'(3) + scy_x4);
    end
  end
endmodule

// File: rtl/nfr_byte_counter.sv
module nfr_byte_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             dec_i,
  output logic             last_o
);
  logic [CNT_W-1:0] rem_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q <= '0;
    end else if (load_i) begin
      rem_q <= count_i;
    end else if (dec_i) begin
      rem_q <= rem_q - 1'b1;
    end
  end

  assign last_o = (rem_q == CNT_W'(1));

  a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
    dec_i |-> (rem_q != '0));
endmodule

// File: rtl/nfr_phase_fsm.sv
module nfr_phase_fsm #(
  parameter int TICK_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              accept_i,
  input  logic              zero_i,
  input  logic [TICK_W-1:0] wait_t_i,
  input  logic [TICK_W-1:0] low_t_i,
  input  logic [TICK_W-1:0] high_t_i,
  input  logic [TICK_W-1:0] hold_t_i,
  input  logic [TICK_W-1:0] ext_t_i,
  input  logic              ext_en_i,
  input  logic              last_i,
  output logic              ready_o,
  output logic              byte_done_o,
  output logic              cs_n_o,
  output logic              re_n_o,
  output logic              cap_o,
  output logic              busy_o,
  output logic              done_o
);
  import nfr_pkg::*;

  phase_e            st_q, st_d;
  logic [TICK_W-1:0] cnt_q, cnt_d;
  logic              expired;

  assign expired     = (cnt_q == '0);
  assign ready_o     = (st_q == PH_IDLE) || (st_q == PH_DONE);
  assign byte_done_o = (st_q == PH_LOW) && expired;

  // Phase after the last byte: hold, then optional release, then done.
  function automatic phase_e after_low(input logic [TICK_W-1:0] hold_t,
                                       input logic ext_en);
    if (hold_t != '0)  return PH_HOLD;
    else if (ext_en)   return PH_EXT;
    else               return PH_DONE;
  endfunction

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      PH_IDLE, PH_DONE: begin
        st_d = PH_IDLE;
        if (accept_i) begin
          if (zero_i) begin
            st_d = PH_DONE;
          end else begin
            st_d  = PH_WAIT;
            cnt_d = wait_t_i - 1'b1;
          end
        end
      end
      PH_WAIT: begin
        if (expired) begin
          st_d  = PH_LOW;
          cnt_d = low_t_i - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LOW: begin
        if (expired) begin
          if (last_i) begin
            st_d = after_low(hold_t_i, ext_en_i);
            if (st_d == PH_HOLD)     cnt_d = hold_t_i - 1'b1;
            else if (st_d == PH_EXT) cnt_d = ext_t_i - 1'b1;
            else                     cnt_d = '0;
          end else begin
            st_d  = PH_HIGH;
            cnt_d = high_t_i - 1'b1;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (expired) begin
          st_d  = PH_LOW;
          cnt_d = low_t_i - 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HOLD: begin
        if (expired) begin
          st_d  = ext_en_i ? PH_EXT : PH_DONE;
          cnt_d = ext_en_i ? (ext_t_i - 1'b1) : '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_EXT: begin
        if (expired) begin
          st_d  = PH_DONE;
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        st_d  = PH_IDLE;
        cnt_d = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= PH_IDLE;
      cnt_q  <= '0;
      cs_n_o <= 1'b1;
      re_n_o <= 1'b1;
      cap_o  <= 1'b0;
      busy_o <= 1'b0;
      done_o <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      cs_n_o <= !(st_d inside {PH_WAIT, PH_LOW, PH_HIGH, PH_HOLD});
      re_n_o <= (st_d != PH_LOW);
      cap_o  <= (st_d == PH_LOW) && (cnt_d == '0);
      busy_o <= !(st_d inside {PH_IDLE, PH_DONE});
      done_o <= (st_d == PH_DONE);
    end
  end

  a_r6_ext_releases_cs: assert property (@(posedge clk) disable iff (rst)
    (st_q == PH_EXT) |-> (cs_n_o && busy_o && re_n_o));

  a_r4_cap_inside_low: assert property (@(posedge clk) disable iff (rst)
    cap_o |-> (!re_n_o && !cs_n_o));

  a_r7_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && cs_n_o));

  a_r9_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start_i && (st_q == PH_WAIT) && !expired) |=> (st_q == PH_WAIT));

  a_r1_low_holds: assert property (@(posedge clk) disable iff (rst)
    ((st_q == PH_LOW) && !expired) |=> !re_n_o);
endmodule

// File: rtl/nand_read_strobe_seq.sv
module nand_read_strobe_seq #(
  parameter int CNT_W  = 8,
  parameter int SCY_W  = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] byte_cnt_i,
  input  logic             relaxed_i,
  input  logic             shift_i,
  input  logic [SCY_W-1:0] scy_i,
  input  logic             ext_hold_i,
  output logic             cs_n_o,
  output logic             re_n_o,
  output logic             cap_o,
  output logic             done_o,
  output logic             busy_o
);
  localparam int TICK_W = SCY_W + 4;

  logic [TICK_W-1:0] wait_live, low_live, high_live, hold_live, ext_live;
  logic [TICK_W-1:0] low_q, high_q, hold_q, ext_q;
  logic              ext_en_q;
  logic              ready, accept, byte_done, last_byte;

  assign accept = start_i && ready;

  nfr_timing_calc #(.SCY_W(SCY_W), .TICK_W(TICK_W)) u_calc (
    .relaxed_i (relaxed_i),
    .shift_i   (shift_i),
    .scy_i     (scy_i),
    .wait_t_o  (wait_live),
    .low_t_o   (low_live),
    .high_t_o  (high_live),
    .hold_t_o  (hold_live),
    .ext_t_o   (ext_live)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      low_q    <= '0;
      high_q   <= '0;
      hold_q   <= '0;
      ext_q    <= '0;
      ext_en_q <= 1'b0;
    end else if (accept) begin
      low_q    <= low_live;
      high_q   <= high_live;
      hold_q   <= hold_live;
      ext_q    <= ext_live;
      ext_en_q <= ext_hold_i;
    end
  end

  nfr_byte_counter #(.CNT_W(CNT_W)) u_bytes (
    .clk     (clk),
    .rst     (rst),
    .load_i  (accept),
    .count_i (byte_cnt_i),
    .dec_i   (byte_done),
    .last_o  (last_byte)
  );

  nfr_phase_fsm #(.TICK_W(TICK_W)) u_fsm (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .accept_i    (accept),
    .zero_i      (byte_cnt_i == '0),
    .wait_t_i    (wait_live),
    .low_t_i     (low_q),
    .high_t_i    (high_q),
    .hold_t_i    (hold_q),
    .ext_t_i     (ext_q),
    .ext_en_i    (ext_en_q),
    .last_i      (last_byte),
    .ready_o     (ready),
    .byte_done_o (byte_done),
    .cs_n_o      (cs_n_o),
    .re_n_o      (re_n_o),
    .cap_o       (cap_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  a_r2_cs_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> (!cs_n_o && re_n_o));
endmodule

// File: tb/nand_read_strobe_seq_tb.sv
module nand_read_strobe_seq_tb;
  localparam int CNT_W = 8;
  localparam int SCY_W = 4;
  localparam int MAXV  = 4096;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             start_i = 1'b0;
  logic [CNT_W-1:0] byte_cnt_i = '0;
  logic             relaxed_i = 1'b0;
  logic             shift_i = 1'b0;
  logic [SCY_W-1:0] scy_i = '0;
  logic             ext_hold_i = 1'b0;
  logic             cs_n_o, re_n_o, cap_o, done_o, busy_o;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  bit e_cs[MAXV];
  bit e_re[MAXV];
  bit e_cap[MAXV];
  bit e_busy[MAXV];
  bit e_done[MAXV];
  int e_tag[MAXV];
  int len;

  always #10 clk = ~clk;

  nand_read_strobe_seq #(.CNT_W(CNT_W), .SCY_W(SCY_W)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .byte_cnt_i(byte_cnt_i),
    .relaxed_i(relaxed_i), .shift_i(shift_i), .scy_i(scy_i),
    .ext_hold_i(ext_hold_i), .cs_n_o(cs_n_o), .re_n_o(re_n_o),
    .cap_o(cap_o), .done_o(done_o), .busy_o(busy_o)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog R7: actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic string tag_name(input int k);
    case (k)
      1:  return "R1";
      2:  return "R2";
      3:  return "R3";
      4:  return "R4";
      5:  return "R5";
      6:  return "R6";
      7:  return "R7";
      8:  return "R8";
      9:  return "R9";
      10: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic push(input bit cs, input bit re, input bit cap,
                      input bit busy, input bit done, input int tag);
    e_cs[len] = cs; e_re[len] = re; e_cap[len] = cap;
    e_busy[len] = busy; e_done[len] = done; e_tag[len] = tag;
    len++;
  endtask

  // Expected waveform, tick 0 = first tick after the accepting edge.
  task automatic build(input int n, input bit r, input bit s,
                       input int scy, input bit e);
    int wt, lo, hi, ho, ex;
    len = 0;
    if (n == 0) begin
      push(1, 1, 0, 0, 1, 8);
      push(1, 1, 0, 0, 0, 8);
      return;
    end
    wt = r ? 12 + 8*scy : 8 + 4*scy;
    if (r) lo = s ? 4 + 8*scy : 2 + 8*scy;
    else   lo = s ? 4 + 4*scy : 3 + 4*scy;
    hi = r ? 8 : 4;
    ho = r ? 8*scy : 4*scy;
    ex = r ? 8 : 4;
    for (int i = 0; i < wt; i++) push(0, 1, 0, 1, 0, 2);
    for (int b = 0; b < n; b++) begin
      for (int i = 0; i < lo; i++)
        push(0, 0, (i == lo-1), 1, 0, (i == lo-1) ? 4 : 1);
      if (b < n-1)
        for (int i = 0; i < hi; i++) push(0, 1, 0, 1, 0, 3);
    end
    for (int i = 0; i < ho; i++) push(0, 1, 0, 1, 0, 5);
    if (e) for (int i = 0; i < ex; i++) push(1, 1, 0, 1, 0, 6);
    push(1, 1, 0, 0, 1, 7);
    push(1, 1, 0, 0, 0, 7);
  endtask

  task automatic cmp_tick(input string name, input int t, input int tag);
    vectors++;
    if ({cs_n_o, re_n_o, cap_o, busy_o, done_o} !==
        {e_cs[t], e_re[t], e_cap[t], e_busy[t], e_done[t]}) begin
      errors++;
      $display("FAIL %s %s tick %0d: actual cs_n,re_n,cap,busy,done=%b%b%b%b%b expected=%b%b%b%b%b",
               tag_name(tag), name, t, cs_n_o, re_n_o, cap_o, busy_o, done_o,
               e_cs[t], e_re[t], e_cap[t], e_busy[t], e_done[t]);
    end
  endtask

  // disturb: 0 none, 1 start pulse while busy (R9), 2 inputs changed mid-burst (R11)
  task automatic run(input string name, input int n, input bit r, input bit s,
                     input int scy, input bit e, input int disturb);
    build(n, r, s, scy, e);
    @(negedge clk);
    byte_cnt_i = CNT_W'(n); relaxed_i = r; shift_i = s;
    scy_i = SCY_W'(scy); ext_hold_i = e; start_i = 1'b1;
    for (int t = 0; t < len; t++) begin
      @(negedge clk);
      cmp_tick(name, t, (disturb == 1) ? 9 : (disturb == 2) ? 11 : e_tag[t]);
      start_i = 1'b0;
      if (disturb == 1 && t == 4) begin
        start_i = 1'b1; byte_cnt_i = '0;
      end
      if (disturb == 2 && t == 0) begin
        relaxed_i = ~r; shift_i = ~s; scy_i = ~SCY_W'(scy);
        ext_hold_i = ~e; byte_cnt_i = CNT_W'(n + 3);
      end
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    vectors++;
    if ({cs_n_o, re_n_o, cap_o, busy_o, done_o} !== 5'b11000) begin
      errors++;
      $display("FAIL R10 reset: actual=%b%b%b%b%b expected=11000",
               cs_n_o, re_n_o, cap_o, busy_o, done_o);
    end
  endtask

  task automatic t_basic();        run("basic_r0s0", 3, 0, 0, 1, 0, 0); endtask
  task automatic t_shift_no_hold(); run("shift_scy0", 2, 0, 1, 0, 0, 0); endtask
  task automatic t_min_low_ext();  run("min_low_ext", 4, 0, 0, 0, 1, 0); endtask
  task automatic t_relaxed_ext();  run("relaxed_ext", 2, 1, 0, 2, 1, 0); endtask
  task automatic t_relaxed_min();  run("relaxed_scy0", 3, 1, 0, 0, 0, 0); endtask
  task automatic t_max_scy();      run("max_scy_r1s1", 1, 1, 1, 15, 1, 0); endtask
  task automatic t_zero();         run("zero_count", 0, 1, 1, 5, 1, 0); endtask
  task automatic t_busy_start();   run("start_while_busy", 2, 0, 1, 2, 1, 1); endtask
  task automatic t_opt_change();   run("options_change", 2, 0, 0, 1, 0, 2); endtask

  initial begin
    t_reset();
    t_basic();
    t_shift_no_hold();
    t_min_low_ext();
    t_relaxed_ext();
    t_relaxed_min();
    t_max_scy();
    t_zero();
    t_busy_start();
    t_opt_change();
    t_basic();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule